// File: doc/BRIEF.md
# CPU Sleep Mode Controller

This block sequences the power modes of a small microcontroller core. A sleep strobe from the CPU stops the CPU clock while the peripheral clock keeps running. An enabled and unmasked interrupt, or the non-maskable interrupt, brings the CPU back and starts exception handling. Because sleep only gates the clock and never resets the core, the CPU registers keep their contents through a sleep period.

Two asynchronous, active-low pins override everything else. The reset pin forces a reset-hold state. The CPU is released from that state only after the pin has stayed high for a settling interval counted in clock cycles. The standby pin forces hardware standby from any state, and both clocks stop while it is low. If the standby-select bit is set when the sleep strobe arrives, the controller does not enter sleep. It issues a one-cycle software-standby request instead, because the clock dividers that act on that request are outside this block.

The synchronous, active-high `rst` input places the block in reset-hold. It then releases the CPU through the same settling sequence that the reset pin uses.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst`, the outputs read: `cpu_clk_en`=0, `per_clk_en`=1, `rst_req`=1, `hw_standby`=0, `wake_pulse`=0 and `wake_cause`=0.
- R2: In the running state, `sleep_strobe`=1 with `ssby_sel`=0 drops `cpu_clk_en` on the next cycle. `per_clk_en` stays 1 and `rst_req` stays 0.
- R3: In the running state, `sleep_strobe`=1 with `ssby_sel`=1 raises `sw_standby_req` for exactly one cycle. `cpu_clk_en` stays 1.
- R4: In sleep, a source i with `irq_req[i]`=1, `irq_en[i]`=1 and `cpu_mask`=0 ends sleep on the next cycle. On that same cycle `wake_pulse`=1, `wake_cause`=1 and `cpu_clk_en`=1.
- R5: In sleep, a request whose enable bit is 0, or any maskable request while `cpu_mask`=1, leaves `cpu_clk_en`=0 and `wake_pulse`=0.
- R6: In sleep, `nmi`=1 ends sleep whatever the mask is, with `wake_cause`=2. When NMI and a qualified maskable request arrive together, the cause is 2.
- R7: `res_n_pin` passes through two synchronizer flops. A low level acts on the third rising edge and moves the block from running or sleep into reset-hold, with `rst_req`=1 and `cpu_clk_en`=0.
- R8: In reset-hold, once `res_n_pin` has been high for SETTLE_CYC consecutive synchronized cycles, the block issues `wake_pulse` with `wake_cause`=3 and returns to running. When the pin is released at one edge, this happens at the edge SETTLE_CYC+2 edges later.
- R9: If the synchronized reset pin goes low before the settling count completes, the count restarts and no pulse is issued.
- R10: `stby_n_pin` low, after two-flop synchronization, forces hardware standby from any state: `hw_standby`=1, both clock enables 0, `rst_req`=1. It takes priority over the reset pin. Releasing it moves the block to reset-hold.
- R11: `wake_pulse` lasts exactly one cycle. Interrupts that arrive while the CPU is running produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_strobe | input | 1 | Sleep instruction executed |
| ssby_sel | input | 1 | Standby-select control bit |
| irq_req | input | N_IRQ | Maskable interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| cpu_mask | input | 1 | CPU interrupt mask (maskable sources only) |
| nmi | input | 1 | Non-maskable interrupt |
| res_n_pin | input | 1 | Asynchronous active-low reset pin |
| stby_n_pin | input | 1 | Asynchronous active-low standby pin |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wake_pulse | output | 1 | One-cycle exception-start pulse |
| wake_cause | output | 2 | 0 none, 1 IRQ, 2 NMI, 3 reset |
| rst_req | output | 1 | Reset request to the core |
| hw_standby | output | 1 | Hardware standby indication |
| sw_standby_req | output | 1 | One-cycle software-standby request |

## Verification
The bench builds the block with N_IRQ=4 and SETTLE_CYC=4. With only four sources, the vector table can cover enabled, disabled, masked and mixed request patterns. A four-cycle settling window lets the bench release the reset pin and then pull it low partway through the count. It also makes it practical to check the exact edge on which the reset-exception pulse appears, relative to the two synchronizer stages.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_RHOLD = 2'd2,
    ST_HSTBY = 2'd3
  } pmode_t;

  typedef enum logic [1:0] {
    CS_NONE = 2'd0,
    CS_IRQ  = 2'd1,
    CS_NMI  = 2'd2,
    CS_RST  = 2'd3
  } wcause_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  // Both stages reset to 1 so that an idle (high) pin never shows a false low.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '1;
      sync_out <= '1;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             cpu_mask,
  input  logic             nmi,
  output logic             irq_wake,
  output logic             nmi_wake
);
  logic [N_IRQ-1:0] live;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_src
      assign live[g] = irq_req[g] & irq_en[g];
    end
  endgenerate

  assign irq_wake = (|live) & ~cpu_mask;
  assign nmi_wake = nmi;
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  // Any cycle without run restarts the interval.
  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int SETTLE_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_strobe,
  input  logic             ssby_sel,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             cpu_mask,
  input  logic             nmi,
  input  logic             res_n_pin,
  input  logic             stby_n_pin,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             wake_pulse,
  output logic [1:0]       wake_cause,
  output logic             rst_req,
  output logic             hw_standby,
  output logic             sw_standby_req
);
  pmode_t     state, nxt;
  wcause_t    cause_n;
  logic       wake_n, swsb_n;
  logic [1:0] pins_s;
  logic       res_s, stby_s;
  logic       irq_w, nmi_w, settle_done;

  pin_sync #(.W(2)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({stby_n_pin, res_n_pin}),
    .sync_out(pins_s)
  );
  assign res_s  = pins_s[0];
  assign stby_s = pins_s[1];

  wake_qual #(.N_IRQ(N_IRQ)) u_qual (
    .irq_req(irq_req), .irq_en(irq_en), .cpu_mask(cpu_mask), .nmi(nmi),
    .irq_wake(irq_w), .nmi_wake(nmi_w)
  );

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst),
    .run((state == ST_RHOLD) && res_s && stby_s),
    .done(settle_done)
  );

  // Priority: standby pin, reset pin, NMI, maskable interrupts.
  always_comb begin
    nxt     = state;
    wake_n  = 1'b0;
    cause_n = CS_NONE;
    swsb_n  = 1'b0;
    if (!stby_s) begin
      nxt = ST_HSTBY;
    end else begin
      case (state)
        ST_RUN: begin
          if (!res_s)            nxt = ST_RHOLD;
          else if (sleep_strobe) begin
            if (ssby_sel) swsb_n = 1'b1;
            else          nxt    = ST_SLEEP;
          end
        end
        ST_SLEEP: begin
          if (!res_s) nxt = ST_RHOLD;
          else if (nmi_w) begin
            nxt = ST_RUN; wake_n = 1'b1; cause_n = CS_NMI;
          end else if (irq_w) begin
            nxt = ST_RUN; wake_n = 1'b1; cause_n = CS_IRQ;
          end
        end
        ST_RHOLD: begin
          if (settle_done) begin
            nxt = ST_RUN; wake_n = 1'b1; cause_n = CS_RST;
          end
        end
        default: nxt = ST_RHOLD;  // standby released: go through reset
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_RHOLD;
      cpu_clk_en     <= 1'b0;
      per_clk_en     <= 1'b1;
      rst_req        <= 1'b1;
      hw_standby     <= 1'b0;
      wake_pulse     <= 1'b0;
      wake_cause     <= 2'd0;
      sw_standby_req <= 1'b0;
    end else begin
      state          <= nxt;
      cpu_clk_en     <= (nxt == ST_RUN);
      per_clk_en     <= (nxt != ST_HSTBY);
      rst_req        <= (nxt == ST_RHOLD) || (nxt == ST_HSTBY);
      hw_standby     <= (nxt == ST_HSTBY);
      wake_pulse     <= wake_n;
      wake_cause     <= cause_n;
      sw_standby_req <= swsb_n;
    end
  end
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       wake_pulse,
  input logic [1:0] wake_cause,
  input logic       rst_req,
  input logic       hw_standby,
  input logic       sw_standby_req
);
  AST_SLEEP_PER_RUNS: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && !rst_req) |-> per_clk_en); // R2
  AST_SWSB_KEEPS_CPU: assert property (@(posedge clk) disable iff (rst)
    sw_standby_req |-> cpu_clk_en); // R3
  AST_SWSB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sw_standby_req |=> !sw_standby_req); // R3
  AST_WAKE_CLK_ON: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (cpu_clk_en && !rst_req)); // R4
  AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (wake_cause != 2'd0)); // R4
  AST_NO_CAUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wake_pulse |-> (wake_cause == 2'd0)); // R6
  AST_RESET_STOPS_CPU: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !cpu_clk_en); // R7
  AST_STBY_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    hw_standby |-> (!cpu_clk_en && !per_clk_en && rst_req)); // R10
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse); // R11
  AST_WAKE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en) |-> wake_pulse); // R11
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk(clk), .rst(rst), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .wake_pulse(wake_pulse), .wake_cause(wake_cause), .rst_req(rst_req),
  .hw_standby(hw_standby), .sw_standby_req(sw_standby_req)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int NI = 4;
  localparam int ST = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_strobe = 0, ssby_sel = 0, cpu_mask = 0, nmi = 0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic res_n_pin = 1, stby_n_pin = 1;
  logic cpu_clk_en, per_clk_en, wake_pulse, rst_req, hw_standby, sw_standby_req;
  logic [1:0] wake_cause;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.N_IRQ(NI), .SETTLE_CYC(ST)) uut (
    .clk(clk), .rst(rst), .sleep_strobe(sleep_strobe), .ssby_sel(ssby_sel),
    .irq_req(irq_req), .irq_en(irq_en), .cpu_mask(cpu_mask), .nmi(nmi),
    .res_n_pin(res_n_pin), .stby_n_pin(stby_n_pin),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wake_pulse(wake_pulse),
    .wake_cause(wake_cause), .rst_req(rst_req), .hw_standby(hw_standby),
    .sw_standby_req(sw_standby_req)
  );

  // Vector: {exp_cause[1:0], nmi, mask, en[3:0], req[3:0]}; exp_cause 0 = stays asleep
  localparam logic [11:0] VEC [8] = '{
    {2'd1, 1'b0, 1'b0, 4'b0001, 4'b0001},  // R4 enabled, unmasked
    {2'd0, 1'b0, 1'b0, 4'b0000, 4'b0001},  // R5 disabled
    {2'd0, 1'b0, 1'b1, 4'b0100, 4'b0100},  // R5 masked
    {2'd2, 1'b1, 1'b1, 4'b1111, 4'b0000},  // R6 NMI while masked
    {2'd2, 1'b1, 1'b0, 4'b1000, 4'b1000},  // R6 NMI beats IRQ
    {2'd1, 1'b0, 1'b0, 4'b0110, 4'b0010},  // R4 one of several enabled
    {2'd0, 1'b0, 1'b0, 4'b1111, 4'b0000},  // R5 no request
    {2'd0, 1'b0, 1'b0, 4'b0101, 4'b1010}   // R5 request/enable mismatch
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {1'b0, sw_standby_req, wake_cause, wake_pulse, hw_standby, rst_req, cpu_clk_en} |
           8'(per_clk_en) << 7;
  endfunction

  // {per, swsb, cause[1:0], wake, hw, rst_req, cpu}
  initial begin
    repeat (3) tick();
    chk("R1 reset outputs", outs(), 8'b1000_0010);
    rst = 0;
    repeat (ST - 1) tick();
    chk("R8 no early pulse after rst", {7'd0, wake_pulse}, 8'd0);
    tick();
    chk("R8 reset exception after rst", {4'd0, wake_cause, wake_pulse, cpu_clk_en}, 8'b0000_1111);
    tick();
    chk("R11 pulse one cycle", {7'd0, wake_pulse}, 8'd0);

    // R3 software standby request
    sleep_strobe = 1; ssby_sel = 1; tick();
    sleep_strobe = 0; ssby_sel = 0;
    chk("R3 swsb pulse, cpu on", {6'd0, sw_standby_req, cpu_clk_en}, 8'b11);
    tick();
    chk("R3 swsb one cycle", {6'd0, sw_standby_req, cpu_clk_en}, 8'b01);

    // Vector walk: sleep, apply interrupts, check wake
    for (int i = 0; i < 8; i++) begin
      sleep_strobe = 1; tick(); sleep_strobe = 0;
      chk("R2 sleep clocks", {5'd0, per_clk_en, rst_req, cpu_clk_en}, 8'b100);
      irq_req = VEC[i][3:0]; irq_en = VEC[i][7:4];
      cpu_mask = VEC[i][8]; nmi = VEC[i][9];
      tick();
      irq_req = '0; irq_en = '0; cpu_mask = 0; nmi = 0;
      chk((VEC[i][11:10] == 2'd0) ? "R5 no wake" : "R4/R6 wake",
          {5'd0, wake_cause, wake_pulse}, {5'd0, VEC[i][11:10], VEC[i][11:10] != 2'd0});
      chk("R4 cpu clock with wake", {7'd0, cpu_clk_en}, {7'd0, VEC[i][11:10] != 2'd0});
      if (VEC[i][11:10] == 2'd0) begin
        tick();
        chk("R5 still asleep", {6'd0, wake_pulse, cpu_clk_en}, 8'd0);
        nmi = 1; tick(); nmi = 0;
        chk("R6 nmi wake", {5'd0, wake_cause, wake_pulse}, 8'b101);
      end
      tick();
      chk("R11 pulse ends", {6'd0, wake_pulse, cpu_clk_en}, 8'b01);
    end

    // R11 interrupts while running give no pulse
    irq_req = '1; irq_en = '1; nmi = 1; tick(); tick();
    chk("R11 no pulse in run", {6'd0, wake_pulse, cpu_clk_en}, 8'b01);
    irq_req = '0; irq_en = '0; nmi = 0;

    // R7 reset pin from sleep, R8 exact exit timing
    sleep_strobe = 1; tick(); sleep_strobe = 0;
    res_n_pin = 0; tick(); tick();
    chk("R7 sync delay", {6'd0, rst_req, cpu_clk_en}, 8'b00);
    tick();
    chk("R7 reset hold", {6'd0, rst_req, cpu_clk_en}, 8'b10);
    res_n_pin = 1;
    repeat (ST + 1) tick();
    chk("R8 still holding", {6'd0, rst_req, wake_pulse}, 8'b10);
    tick();
    chk("R8 reset exception", {4'd0, wake_cause, wake_pulse, rst_req}, 8'b0000_1110);

    // R9 early drop restarts count
    res_n_pin = 0; repeat (4) tick();
    res_n_pin = 1; repeat (3) tick();
    res_n_pin = 0;
    begin
      int seen = 0;
      for (int k = 0; k < ST + 4; k++) begin tick(); if (wake_pulse) seen++; end
      chk("R9 no pulse on abort", 8'(seen), 8'd0);
    end
    res_n_pin = 1;
    repeat (ST + 2) tick();
    chk("R9 full count then exit", {5'd0, wake_cause, wake_pulse}, 8'b111);

    // R10 standby with reset pin also low: standby wins
    tick();
    stby_n_pin = 0; res_n_pin = 0; tick(); tick();
    chk("R10 sync delay", {7'd0, hw_standby}, 8'd0);
    tick();
    chk("R10 standby outputs", {4'd0, per_clk_en, hw_standby, rst_req, cpu_clk_en}, 8'b0110);
    stby_n_pin = 1; repeat (3) tick();
    chk("R10 release to reset hold", {4'd0, per_clk_en, hw_standby, rst_req, cpu_clk_en}, 8'b1010);
    res_n_pin = 1;
    repeat (ST + 2) tick();
    chk("R10 exit via reset", {5'd0, wake_cause, wake_pulse}, 8'b111);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule